// File: doc/BRIEF.md
# Loop-Gain Calibration Sequencer

This block trims the charge-pump current of a fractional-N synthesizer so that loop bandwidth stays put as oscillator tuning sensitivity varies from part to part. Once coarse band selection has finished, the surrounding control logic pulses a start input. If calibration is enabled, the sequencer first drives the unmodified frequency word and samples the loop control voltage through an external converter. It then shifts only the fractional field of the word by a signed step and samples a second time. After each frequency change it waits a programmed number of cycles so the loop can settle.

The difference between the two voltage readings is inversely proportional to the tuning sensitivity. The sequencer scales that difference against a programmed full-scale difference to produce a new current code. The full-scale difference is the swing expected from the weakest oscillator, which therefore receives the largest current. At the end of the run the word returns to its starting value, a one-cycle done pulse is issued, and the new code is held until the next calibration.

Top module: `loop_gain_cal`

## Requirements
- R1: While reset is asserted, icp_code is the full-scale value 2**ICP_W-1 (7 by default), and freq_word, busy and done are all zero.
- R2: While idle, freq_word equals the base_word value sampled on the previous clock edge.
- R3: When cal_en is low, cal_start is ignored. busy and done stay low, icp_code is unchanged, and freq_word keeps following base_word.
- R4: For the second measurement, freq_word is the start-time base word with its upper FW_W-FRAC_W bits unchanged. Its low FRAC_W bits are replaced by the fractional field plus step_mag when step_neg is 0, or minus step_mag when step_neg is 1, taken modulo 2**FRAC_W. This offset word is driven for exactly settle_len+1 cycles.
- R5: done rises exactly 2*settle_len+3 clock edges after the edge that accepts cal_start and stays high for exactly one cycle. busy is high from the accepting edge until done rises.
- R6: On done, icp_code equals floor((2**ICP_W-1) * |v_offset - v_base| / dv_full), clamped to the range 1 to 2**ICP_W-1. A dv_full of zero yields 2**ICP_W-1. Here v_base and v_offset are the vsample values captured at the end of each settle window.
- R7: icp_code changes only in a cycle in which done is high.
- R8: In the cycle where done is high, freq_word again equals the base word captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable; start is ignored while low |
| cal_start | input | 1 | Start request, issued after coarse calibration |
| base_word | input | FW_W | Programmed frequency word (integer over fractional) |
| step_mag | input | STEP_W | Magnitude of the fractional offset |
| step_neg | input | 1 | 1 subtracts the offset, 0 adds it |
| settle_len | input | SET_W | Settle cycles minus one after each frequency change |
| dv_full | input | V_W | Voltage difference that maps to the full-scale code |
| vsample | input | V_W | Converted loop control voltage |
| freq_word | output | FW_W | Frequency word driven to the divider |
| icp_code | output | ICP_W | Charge-pump current code |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 24-bit word with a 16-bit fractional field, a 10-bit voltage and a 3-bit current code. With these widths every clamp boundary can be reached with ordinary sample values, and fractional wraparound in both directions is reached by placing the base fraction near either end of its field. Settle lengths are kept between 0 and 5, so the zero-wait case and the window-length arithmetic are both covered in short runs. A behavioural converter model returns a different voltage whenever the offset word is on the bus, so capturing a sample in the wrong window yields a wrong code.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_OFFS = 2'd2,
    ST_CALC = 2'd3
  } lgc_state_e;
endpackage

// File: rtl/lgc_rst_sync.sv
module lgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lgc_settle_timer.sv
module lgc_settle_timer #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SET_W-1:0] limit,
  output logic             expire
);
  logic [SET_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == limit);
endmodule

// File: rtl/lgc_word_offset.sv
module lgc_word_offset #(
  parameter int FW_W   = 24,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 16
) (
  input  logic [FW_W-1:0]   word_in,
  input  logic [STEP_W-1:0] step_mag,
  input  logic              step_neg,
  output logic [FW_W-1:0]   word_out
);
  logic [FRAC_W-1:0] step_f;
  logic [FRAC_W-1:0] frac_new;

  generate
    if (STEP_W >= FRAC_W) begin : g_step_trunc
      assign step_f = step_mag[FRAC_W-1:0];
    end else begin : g_step_ext
      assign step_f = {{(FRAC_W-STEP_W){1'b0}}, step_mag};
    end
  endgenerate

  assign frac_new = step_neg ? (word_in[FRAC_W-1:0] - step_f)
                             : (word_in[FRAC_W-1:0] + step_f);

  generate
    if (FW_W > FRAC_W) begin : g_with_int
      assign word_out = {word_in[FW_W-1:FRAC_W], frac_new};
    end else begin : g_frac_only
      assign word_out = frac_new;
    end
  endgenerate
endmodule

// File: rtl/lgc_gain_calc.sv
module lgc_gain_calc #(
  parameter int V_W   = 10,
  parameter int ICP_W = 3
) (
  input  logic [V_W-1:0]   v_base,
  input  logic [V_W-1:0]   v_offs,
  input  logic [V_W-1:0]   dv_full,
  output logic [ICP_W-1:0] code
);
  localparam int ICP_MAX = (1 << ICP_W) - 1;
  localparam int PW      = V_W + ICP_W;

  logic [V_W-1:0] dv;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  quot;

  always_comb begin
    dv   = (v_offs >= v_base) ? (v_offs - v_base) : (v_base - v_offs);
    prod = PW'(ICP_MAX) * PW'(dv);
    quot = (dv_full == '0) ? PW'(ICP_MAX) : (prod / PW'(dv_full));
    if (quot > PW'(ICP_MAX))  code = ICP_W'(ICP_MAX);
    else if (quot == '0)      code = ICP_W'(1);
    else                      code = quot[ICP_W-1:0];
  end
endmodule

// File: rtl/loop_gain_cal.sv
module loop_gain_cal
  import lgc_pkg::*;
#(
  parameter int FW_W   = 24,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 16,
  parameter int V_W    = 10,
  parameter int ICP_W  = 3,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_en,
  input  logic              cal_start,
  input  logic [FW_W-1:0]   base_word,
  input  logic [STEP_W-1:0] step_mag,
  input  logic              step_neg,
  input  logic [SET_W-1:0]  settle_len,
  input  logic [V_W-1:0]    dv_full,
  input  logic [V_W-1:0]    vsample,
  output logic [FW_W-1:0]   freq_word,
  output logic [ICP_W-1:0]  icp_code,
  output logic              busy,
  output logic              done
);
  localparam int ICP_MAX = (1 << ICP_W) - 1;

  logic             rst_sync_n;
  lgc_state_e       state_q, state_d;
  logic [FW_W-1:0]  fw_q, fw_d;
  logic [FW_W-1:0]  base_q, base_d;
  logic [V_W-1:0]   v0_q, v0_d;
  logic [V_W-1:0]   v1_q, v1_d;
  logic [ICP_W-1:0] icp_q, icp_d;
  logic             done_q, done_d;
  logic [FW_W-1:0]  offs_word;
  logic [ICP_W-1:0] new_code;
  logic             tmr_clear, tmr_run, tmr_expire;

  lgc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign tmr_run   = (state_q == ST_BASE) || (state_q == ST_OFFS);
  assign tmr_clear = (state_q == ST_IDLE) || tmr_expire;

  lgc_settle_timer #(.SET_W(SET_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .limit  (settle_len),
    .expire (tmr_expire)
  );

  lgc_word_offset #(.FW_W(FW_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_offs (
    .word_in  (base_q),
    .step_mag (step_mag),
    .step_neg (step_neg),
    .word_out (offs_word)
  );

  lgc_gain_calc #(.V_W(V_W), .ICP_W(ICP_W)) u_calc (
    .v_base  (v0_q),
    .v_offs  (v1_q),
    .dv_full (dv_full),
    .code    (new_code)
  );

  always_comb begin
    state_d = state_q;
    fw_d    = fw_q;
    base_d  = base_q;
    v0_d    = v0_q;
    v1_d    = v1_q;
    icp_d   = icp_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        fw_d = base_word;
        if (cal_en && cal_start) begin
          base_d  = base_word;
          state_d = ST_BASE;
        end
      end
      ST_BASE: begin
        if (tmr_expire) begin
          v0_d    = vsample;
          fw_d    = offs_word;
          state_d = ST_OFFS;
        end
      end
      ST_OFFS: begin
        if (tmr_expire) begin
          v1_d    = vsample;
          fw_d    = base_q;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        icp_d   = new_code;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      fw_q    <= '0;
      base_q  <= '0;
      v0_q    <= '0;
      v1_q    <= '0;
      icp_q   <= ICP_W'(ICP_MAX);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fw_q    <= fw_d;
      base_q  <= base_d;
      v0_q    <= v0_d;
      v1_q    <= v1_d;
      icp_q   <= icp_d;
      done_q  <= done_d;
    end
  end

  assign freq_word = fw_q;
  assign icp_code  = icp_q;
  assign done      = done_q;
  assign busy      = (state_q != ST_IDLE);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R6
  icp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    icp_code != '0);

  // R7
  icp_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (icp_code != $past(icp_code)) |-> done);

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !cal_en) |=> !busy);
endmodule

// File: tb/loop_gain_cal_test.sv
`timescale 1ns/1ps
module loop_gain_cal_test;
  localparam int FW_W = 24, FRAC_W = 16, STEP_W = 16, V_W = 10, ICP_W = 3, SET_W = 8;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic cal_en, cal_start, step_neg;
  logic [FW_W-1:0] base_word;
  logic [STEP_W-1:0] step_mag;
  logic [SET_W-1:0] settle_len;
  logic [V_W-1:0] dv_full, vsample;
  logic [FW_W-1:0] freq_word;
  logic [ICP_W-1:0] icp_code;
  logic busy, done;

  logic [FW_W-1:0] exp_off;
  logic [V_W-1:0] v_base, v_off;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign vsample = (freq_word == exp_off) ? v_off : v_base;

  loop_gain_cal uut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cal_start(cal_start),
    .base_word(base_word), .step_mag(step_mag), .step_neg(step_neg),
    .settle_len(settle_len), .dv_full(dv_full), .vsample(vsample),
    .freq_word(freq_word), .icp_code(icp_code), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [FW_W-1:0] f_off(input logic [FW_W-1:0] b,
                                            input logic [STEP_W-1:0] s, input logic neg);
    logic [FRAC_W-1:0] fr;
    fr = neg ? (b[FRAC_W-1:0] - s) : (b[FRAC_W-1:0] + s);
    return {b[FW_W-1:FRAC_W], fr};
  endfunction

  function automatic int f_code(input int vb, input int vo, input int full);
    int dv, q;
    dv = (vo >= vb) ? vo - vb : vb - vo;
    if (full == 0) return CMAX;
    q = (CMAX * dv) / full;
    if (q > CMAX) q = CMAX;
    if (q < 1) q = 1;
    return q;
  endfunction

  task automatic run_cal(input logic [FW_W-1:0] b, input logic [STEP_W-1:0] s,
                         input logic neg, input int sl, input int vb, input int vo,
                         input int full);
    int n, offc, expc;
    @(negedge clk);
    cal_en = 1'b1; base_word = b; step_mag = s; step_neg = neg;
    settle_len = SET_W'(sl); dv_full = V_W'(full);
    v_base = V_W'(vb); v_off = V_W'(vo); exp_off = f_off(b, s, neg);
    cal_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cal_start = 1'b0;
    base_word = ~b;
    n = 0; offc = 0;
    while (n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (freq_word == exp_off) offc++;
      if (!done) check(busy, "R5 busy", busy, 1);
      if (done) break;
    end
    expc = f_code(vb, vo, full);
    check(n == 2*sl + 3, "R5 latency", n, 2*sl + 3);
    check(offc == sl + 1, "R4 offset cycles", offc, sl + 1);
    check(icp_code == ICP_W'(expc), "R6 code", icp_code, expc);
    check(freq_word == b, "R8 restore", freq_word, b);
    @(negedge clk);
    check(!done, "R5 pulse width", done, 0);
    repeat (3) @(negedge clk);
    check(icp_code == ICP_W'(expc), "R7 hold", icp_code, expc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd715));
    rst_n = 1'b0; cal_en = 1'b0; cal_start = 1'b0; base_word = '0; step_mag = '0;
    step_neg = 1'b0; settle_len = '0; dv_full = '0; v_base = '0; v_off = '0;
    exp_off = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(icp_code == 3'd7, "R1 icp", icp_code, 7);
    check(freq_word == '0, "R1 word", freq_word, 0);
    check(!done && !busy, "R1 flags", {done, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 idle tracking
    base_word = 24'h3A5C71;
    @(negedge clk);
    check(freq_word == 24'h3A5C71, "R2 track", freq_word, 24'h3A5C71);

    // R3 disabled: start ignored
    cal_en = 1'b0; cal_start = 1'b1; base_word = 24'h123456;
    begin
      bit seen = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        cal_start = 1'b0;
        if (busy || done) seen = 1;
      end
      check(!seen, "R3 no activity", seen, 0);
      check(icp_code == 3'd7, "R3 icp unchanged", icp_code, 7);
      check(freq_word == 24'h123456, "R3 word tracks", freq_word, 24'h123456);
    end

    // directed corners
    run_cal(24'h10FFF0, 16'h0020, 1'b0, 0, 100, 400, 300);  // R4 wrap up, R6 clamp max
    run_cal(24'h200010, 16'h0100, 1'b1, 2, 500, 300, 700);  // R4 wrap down, R6 = 2
    run_cal(24'h055555, 16'h0001, 1'b0, 5, 250, 250, 200);  // R6 dv zero -> 1
    run_cal(24'h0A0000, 16'h0800, 1'b1, 1, 10, 900, 0);     // R6 dv_full zero -> max
    run_cal(24'h7F1234, 16'h4000, 1'b0, 3, 600, 700, 700);  // R6 1*7/7 = 1

    // random trials
    for (int t = 0; t < 30; t++) begin
      logic [FW_W-1:0] b;
      logic [STEP_W-1:0] s;
      b = FW_W'($urandom);
      s = STEP_W'($urandom_range(1, 65535));
      run_cal(b, s, 1'($urandom), $urandom_range(0, 5),
              $urandom_range(0, 1023), $urandom_range(0, 1023),
              $urandom_range(0, 1023));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule